// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control unit of a datapath that reuses one memory and one ALU across several clock cycles of each instruction. It holds a state register and drives, in each state, the select lines of the datapath multiplexers and the write enables of the instruction register, register file, memory and program counter. Each supported instruction passes through three to five states. The first state fetches the instruction and advances the program counter. The second reads the two source registers and forms a branch target. The instruction class then decides the remaining steps. The outputs depend only on the current state. The 6-bit opcode input, taken from the held instruction register, is used only to choose the next state.

Five instruction classes are supported: load, store, register-to-register arithmetic, branch-if-equal and jump. If the opcode matches none of them, the block goes back to the fetch state once decode ends.

Top module: `mc_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is fetch. This holds from any state.
- R2: The fetch state drives `mem_rd`=1, `ir_we`=1, `pc_we`=1, `addr_sel`=0, `alu_a_sel`=0 (PC), `alu_b_sel`=01 (constant 4), `alu_op`=00 (add) and `pc_src`=00 (ALU result). Every other output is 0.
- R3: The state after fetch is always decode. Decode drives `alu_a_sel`=0, `alu_b_sel`=11 (shifted offset) and `alu_op`=00, with every enable at 0.
- R4: A load (opcode 35) follows decode with an address state: `alu_a_sel`=1, `alu_b_sel`=10 (sign-extended offset), `alu_op`=00, all enables 0.
- R5: A load then has a read state (`addr_sel`=1, `mem_rd`=1), then a write-back state (`rf_we`=1, `dst_sel`=0, `wb_sel`=1), then fetch. In total it takes 5 cycles.
- R6: A store (opcode 43) uses the same address state, then a write state (`addr_sel`=1, `mem_wr`=1), then fetch. In total it takes 4 cycles.
- R7: An arithmetic instruction (opcode 0) has an execute state (`alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=10 function field), then a write state (`dst_sel`=1, `wb_sel`=0, `rf_we`=1), then fetch. In total it takes 4 cycles.
- R8: Branch-if-equal (opcode 4) has one final state: `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01 (subtract), `pc_src`=01 (ALU output register), `pc_we_cond`=1. It then returns to fetch, for 3 cycles in total.
- R9: A jump (opcode 2) has one final state with `pc_we`=1 and `pc_src`=10 (jump target). It then returns to fetch, for 3 cycles in total.
- R10: Any other opcode goes from decode straight back to fetch.
- R11: In every state, each output not listed for that state is 0. `mem_rd` and `mem_wr` are never both 1, and `pc_we` and `pc_we_cond` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset to fetch |
| opcode | input | 6 | Opcode field of the held instruction |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| ir_we | output | 1 | Instruction register write enable |
| dst_sel | output | 1 | Destination register: 0 rt field, 1 rd field |
| wb_sel | output | 1 | Write-back data: 0 ALU output register, 1 memory data register |
| rf_we | output | 1 | Register file write enable |
| alu_a_sel | output | 1 | ALU operand A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU operand B: 00 B, 01 four, 10 offset, 11 shifted offset |
| alu_op | output | 2 | 00 add, 01 subtract, 10 by function field |
| pc_src | output | 2 | PC source: 00 ALU result, 01 ALU output register, 10 jump target |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_cond | output | 1 | PC write if the ALU result is zero |

## Verification
In the fetch state, the instruction read into the instruction register and the PC+4 write into the program counter happen in the same cycle. The bench therefore compares every output at once in each fetch cycle, so a missing `ir_we`, `pc_we` or `mem_rd` is caught wherever it occurs. A reset can also arrive in the middle of a load's memory read and collide with the next-state choice. The bench provokes this by raising `rst` in the read state and expects the fetch outputs in the following cycle, with decode one cycle after reset is released. Unknown opcodes are placed between valid instructions to confirm that the sequence resumes at fetch.

// File: rtl/mc_seq.sv
module mc_seq #(
  parameter int OPW = 6,
  parameter logic [OPW-1:0] OP_ARITH = 6'd0,
  parameter logic [OPW-1:0] OP_JUMP  = 6'd2,
  parameter logic [OPW-1:0] OP_BEQ   = 6'd4,
  parameter logic [OPW-1:0] OP_LOAD  = 6'd35,
  parameter logic [OPW-1:0] OP_STORE = 6'd43
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  output logic           addr_sel,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           ir_we,
  output logic           dst_sel,
  output logic           wb_sel,
  output logic           rf_we,
  output logic           alu_a_sel,
  output logic [1:0]     alu_b_sel,
  output logic [1:0]     alu_op,
  output logic [1:0]     pc_src,
  output logic           pc_we,
  output logic           pc_we_cond
);

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_ADDR, S_RD, S_LWB, S_WR, S_EXEC, S_RWB, S_BEQ, S_JMP
  } step_t;

  step_t st, st_nx;

  wire is_mem   = (opcode == OP_LOAD) || (opcode == OP_STORE);
  wire is_known = is_mem || (opcode == OP_ARITH) || (opcode == OP_BEQ) || (opcode == OP_JUMP);

  always_ff @(posedge clk) begin
    if (rst) st <= S_FETCH;
    else     st <= st_nx;
  end

  always_comb begin
    st_nx = S_FETCH;
    case (st)
      S_FETCH:  st_nx = S_DECODE;
      S_DECODE: begin
        if (is_mem)                 st_nx = S_ADDR;
        else if (opcode == OP_ARITH) st_nx = S_EXEC;
        else if (opcode == OP_BEQ)   st_nx = S_BEQ;
        else if (opcode == OP_JUMP)  st_nx = S_JMP;
        else                         st_nx = S_FETCH;
      end
      S_ADDR: begin
        if (opcode == OP_LOAD)       st_nx = S_RD;
        else if (opcode == OP_STORE) st_nx = S_WR;
        else                         st_nx = S_FETCH;
      end
      S_RD:    st_nx = S_LWB;
      S_EXEC:  st_nx = S_RWB;
      default: st_nx = S_FETCH;
    endcase
  end

  always_comb begin
    addr_sel = 1'b0; mem_rd = 1'b0; mem_wr = 1'b0; ir_we = 1'b0;
    dst_sel = 1'b0; wb_sel = 1'b0; rf_we = 1'b0; alu_a_sel = 1'b0;
    alu_b_sel = 2'b00; alu_op = 2'b00; pc_src = 2'b00;
    pc_we = 1'b0; pc_we_cond = 1'b0;
    case (st)
      S_FETCH: begin
        mem_rd = 1'b1; ir_we = 1'b1; alu_b_sel = 2'b01; pc_we = 1'b1;
      end
      S_DECODE: alu_b_sel = 2'b11;
      S_ADDR: begin
        alu_a_sel = 1'b1; alu_b_sel = 2'b10;
      end
      S_RD: begin
        addr_sel = 1'b1; mem_rd = 1'b1;
      end
      S_LWB: begin
        rf_we = 1'b1; wb_sel = 1'b1;
      end
      S_WR: begin
        addr_sel = 1'b1; mem_wr = 1'b1;
      end
      S_EXEC: begin
        alu_a_sel = 1'b1; alu_op = 2'b10;
      end
      S_RWB: begin
        dst_sel = 1'b1; rf_we = 1'b1;
      end
      S_BEQ: begin
        alu_a_sel = 1'b1; alu_op = 2'b01; pc_src = 2'b01; pc_we_cond = 1'b1;
      end
      S_JMP: begin
        pc_src = 2'b10; pc_we = 1'b1;
      end
      default: ;
    endcase
  end

  p_reset_fetch_r1: assert property (@(posedge clk)
    rst |=> (ir_we && mem_rd && pc_we));

  p_decode_follows_r3: assert property (@(posedge clk) disable iff (rst)
    ir_we |=> (!ir_we && alu_b_sel == 2'b11));

  p_read_then_wb_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && addr_sel) |=> (rf_we && wb_sel && !dst_sel));

  p_pc_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(pc_we && pc_we_cond));

  p_jump_returns_r9: assert property (@(posedge clk) disable iff (rst)
    (pc_we && pc_src == 2'b10) |=> ir_we);

  p_unknown_fetch_r10: assert property (@(posedge clk) disable iff (rst)
    (alu_b_sel == 2'b11 && !alu_a_sel && !is_known) |=> ir_we);

  p_rdwr_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

endmodule

// File: tb/sim_mc_seq.sv
module sim_mc_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic addr_sel, mem_rd, mem_wr, ir_we, dst_sel, wb_sel, rf_we, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src;
  logic pc_we, pc_we_cond;

  always #2.5 clk = ~clk;

  mc_seq u0 (
    .clk(clk), .rst(rst), .opcode(opcode),
    .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_we(ir_we),
    .dst_sel(dst_sel), .wb_sel(wb_sel), .rf_we(rf_we), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src),
    .pc_we(pc_we), .pc_we_cond(pc_we_cond)
  );

  wire [15:0] obs = {addr_sel, mem_rd, mem_wr, ir_we, dst_sel, wb_sel, rf_we,
                     alu_a_sel, alu_b_sel, alu_op, pc_src, pc_we, pc_we_cond};

  localparam logic [15:0] V_FETCH = 16'h5042;
  localparam logic [15:0] V_DEC   = 16'h00C0;
  localparam logic [15:0] V_ADDR  = 16'h0180;
  localparam logic [15:0] V_RD    = 16'hC000;
  localparam logic [15:0] V_LWB   = 16'h0600;
  localparam logic [15:0] V_WR    = 16'hA000;
  localparam logic [15:0] V_EXEC  = 16'h0120;
  localparam logic [15:0] V_RWB   = 16'h0A00;
  localparam logic [15:0] V_BEQ   = 16'h0115;
  localparam logic [15:0] V_JMP   = 16'h000A;

  logic [15:0] expq[$];
  logic [5:0]  opq[$];
  string       tagq[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic push(input logic [5:0] op, input logic [15:0] v, input string t);
    expq.push_back(v); opq.push_back(op); tagq.push_back(t);
  endtask

  task automatic instr(input logic [5:0] op);
    push(op, V_FETCH, "R2");
    push(op, V_DEC, "R3");
    case (op)
      6'd35: begin push(op, V_ADDR, "R4"); push(op, V_RD, "R5"); push(op, V_LWB, "R5"); end
      6'd43: begin push(op, V_ADDR, "R4"); push(op, V_WR, "R6"); end
      6'd0:  begin push(op, V_EXEC, "R7"); push(op, V_RWB, "R7"); end
      6'd4:  push(op, V_BEQ, "R8");
      6'd2:  push(op, V_JMP, "R9");
      default: ;
    endcase
  endtask

  task automatic chk(input logic [15:0] exp, input string t);
    checks++;
    if (obs !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", t, obs, exp);
    end
  endtask

  task automatic drain();
    while (expq.size() > 0) begin
      logic [15:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      chk(e, (e == V_FETCH && t == "R2") ? "R2/R11" : t);
      opcode = opq.pop_front();
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(V_FETCH, "R1");
    end
    rst = 1'b0;
    instr(6'd35); instr(6'd43); instr(6'd0); instr(6'd4); instr(6'd2);
    instr(6'h3F);
    instr(6'd35); instr(6'd0); instr(6'd1); instr(6'd2); instr(6'd4);
    instr(6'd43); instr(6'd8);
    drain();
    chk(V_FETCH, "R10");
    push(6'd35, V_FETCH, "R2"); push(6'd35, V_DEC, "R3"); push(6'd35, V_ADDR, "R4");
    drain();
    chk(V_RD, "R5");
    rst = 1'b1;
    @(negedge clk);
    chk(V_FETCH, "R1");
    rst = 1'b0;
    @(negedge clk);
    chk(V_DEC, "R1");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule